// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block keeps the current privilege level and interrupt enable of a hart, together with two older privilege/enable pairs that form a three-level stack. Each cycle it decides whether a synchronous exception or a pending interrupt turns into a trap. Trap entry shifts the stack down and raises the hart to machine level. Trap return shifts the stack up.

When a trap is taken the block registers several results. It issues a one-cycle take strobe and forms a redirect address from the privilege level in force before the trap. It also writes a cause word and the exception PC, and it drops any outstanding load reservation. The surrounding pipeline supplies the pending lines, the exception request and the return request, and acts on the redirect.

Privilege encodings are U = 0, S = 1 and M = 3; the value 2 is never produced.

Top module: `trap_priv_ctrl`

## Requirements
- R1: After reset the status is: current privilege M (3) with enable 0; both stacked levels S (1) with enable 0; memory privilege U (0). The take strobe, cause, exception PC, redirect PC and reservation flag are all 0.
- R2: In a cycle that takes a trap, the following updates happen at the next edge. Level 2 gets level 1. Level 1 gets the current level. The current privilege becomes M with enable 0. The memory privilege becomes M.
- R3: A return request in a cycle that takes no trap shifts the stack up. The current level gets level 1, and level 1 gets level 2. Level 2 then becomes U with enable 1. A return request in a cycle that takes a trap is ignored.
- R4: Together with the take strobe, the redirect PC equals 0x40 times the privilege level that was current before the trap.
- R5: A machine interrupt source is eligible when the current privilege is below M, or when it is M with the enable set. The machine sources are the machine software interrupt and the host message.
- R6: A supervisor source is eligible when the current privilege is U, or when it is S with the enable set. The supervisor sources are the supervisor software interrupt and the supervisor timer, which counts only when its enable input is high.
- R7: Priority runs from high to low as follows: exception, machine software interrupt, host message, supervisor software interrupt, timer. An interrupt cause has the MSB set and the number in the low bits: software = 0, timer = 1, host = 2. An exception cause has the MSB clear and the exception code in the low bits.
- R8: The take strobe is high for exactly one cycle. No trap is taken in the cycle while the strobe is high, even with a request present.
- R9: On a trap the exception PC register captures the PC input of the trapping cycle, and the cause register captures the cause word.
- R10: A reservation-set request raises the reservation flag. A trap clears the flag, and the trap wins when both occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msw_pend_i | input | 1 | Machine software interrupt pending |
| host_msg_i | input | 1 | Host message pending |
| ssw_pend_i | input | 1 | Supervisor software interrupt pending |
| stmr_pend_i | input | 1 | Supervisor timer pending |
| stmr_en_i | input | 1 | Supervisor timer enable |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | CODE_W | Exception code |
| pc_i | input | XLEN | PC of the current instruction |
| ret_req_i | input | 1 | Trap return request |
| resv_set_i | input | 1 | Load reservation set |
| trap_take_o | output | 1 | One-cycle trap strobe |
| trap_pc_o | output | XLEN | Redirect address |
| cause_o | output | XLEN | Cause register |
| epc_o | output | XLEN | Exception PC register |
| priv_o | output | 2 | Current privilege |
| ie_o | output | 1 | Current interrupt enable |
| priv1_o | output | 2 | Stack level 1 privilege |
| ie1_o | output | 1 | Stack level 1 enable |
| priv2_o | output | 2 | Stack level 2 privilege |
| ie2_o | output | 1 | Stack level 2 enable |
| mem_priv_o | output | 2 | Memory access privilege |
| resv_valid_o | output | 1 | Load reservation held |

## Verification
The assertions check the following on every cycle:
- the single-cycle strobe;
- the machine-level state and the stack shift seen with each strobe;
- the redirect address formed from the prior privilege;
- the pop after an accepted return;
- the cleared reservation;
- the absence of traps when every source is ineligible.

Only the bench scenarios can show the full arbitration order among several sources pending together, the exact cause codes, and the captured PC. They can also show the three-deep unwind back to user level, where eligibility then changes. These come from a bench model that tracks the whole state over long random sequences and directed cases.

// File: rtl/trap_pkg.sv
// Shared types and constants for the privilege stack trap controller.
// Assumes privilege is encoded numerically so that a larger value is more privileged.
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef struct packed {
        priv_e prv;
        logic  ie;
    } lvl_t;

    localparam int          IRQ_W      = 2;
    localparam logic [1:0]  IRQ_SW     = 2'd0;
    localparam logic [1:0]  IRQ_TIMER  = 2'd1;
    localparam logic [1:0]  IRQ_HOST   = 2'd2;
    localparam int          VEC_SHIFT  = 6;

    localparam lvl_t LVL_RESET_CUR = '{prv: PRIV_M, ie: 1'b0};
    localparam lvl_t LVL_RESET_STK = '{prv: PRIV_S, ie: 1'b0};
    localparam lvl_t LVL_TRAP      = '{prv: PRIV_M, ie: 1'b0};
    localparam lvl_t LVL_RET_FILL  = '{prv: PRIV_U, ie: 1'b1};

endpackage

// File: rtl/irq_select.sv
// Trap source arbiter. It decides whether any exception or eligible interrupt
// wants a trap this cycle, and it forms the cause word.
// Assumes its inputs are stable in the cycle and have no registers of their own.
module irq_select
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  priv_e              cur_prv,
    input  logic               cur_ie,
    input  logic               msw_pend,
    input  logic               host_msg,
    input  logic               ssw_pend,
    input  logic               stmr_pend,
    input  logic               stmr_en,
    input  logic               exc_req,
    input  logic [CODE_W-1:0]  exc_code,
    output logic               hit,
    output logic [XLEN-1:0]    cause
);

    logic             m_ok;
    logic             s_ok;
    logic             irq_hit;
    logic [IRQ_W-1:0] irq_num;

    // Eligibility of each interrupt class for the present privilege and enable
    always_comb begin
        m_ok = (cur_prv != PRIV_M) || cur_ie;
        s_ok = (cur_prv == PRIV_U) || ((cur_prv == PRIV_S) && cur_ie);
    end

    // Fixed priority across interrupt sources, machine class first
    always_comb begin
        irq_hit = 1'b1;
        irq_num = IRQ_SW;
        if (m_ok && msw_pend)                   irq_num = IRQ_SW;
        else if (m_ok && host_msg)              irq_num = IRQ_HOST;
        else if (s_ok && ssw_pend)              irq_num = IRQ_SW;
        else if (s_ok && stmr_pend && stmr_en)  irq_num = IRQ_TIMER;
        else                                    irq_hit = 1'b0;
    end

    // Cause word: exception wins over interrupts
    always_comb begin
        cause = '0;
        if (exc_req) begin
            cause[CODE_W-1:0] = exc_code;
        end else if (irq_hit) begin
            cause[XLEN-1]    = 1'b1;
            cause[IRQ_W-1:0] = irq_num;
        end
    end

    assign hit = exc_req || irq_hit;

endmodule

// File: rtl/priv_stack.sv
// Privilege/enable shift stack. Entry 0 is the current level. Push shifts every
// entry down one place and loads the trap level at the head. Pop shifts every
// entry up one place and loads the return fill value at the tail.
// Assumes push and pop are never high together.
module priv_stack
    import trap_pkg::*;
#(
    parameter int LEVELS = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    output lvl_t  lvl_o [LEVELS],
    output priv_e mem_prv_o
);

    lvl_t  stk_q [LEVELS];
    priv_e mem_prv_q;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam lvl_t RST_V = (g == 0) ? LVL_RESET_CUR : LVL_RESET_STK;
        lvl_t below_v;
        lvl_t above_v;

        if (g == 0) begin : g_head
            assign below_v = LVL_TRAP;
        end else begin : g_body
            assign below_v = stk_q[g-1];
        end

        if (g == LEVELS - 1) begin : g_tail
            assign above_v = LVL_RET_FILL;
        end else begin : g_mid
            assign above_v = stk_q[g+1];
        end

        // Shift this stack entry on push or pop
        always_ff @(posedge clk) begin
            if (!rst_n)     stk_q[g] <= RST_V;
            else if (push)  stk_q[g] <= below_v;
            else if (pop)   stk_q[g] <= above_v;
        end
    end

    // Memory access privilege forced to machine level on trap entry
    always_ff @(posedge clk) begin
        if (!rst_n)     mem_prv_q <= PRIV_U;
        else if (push)  mem_prv_q <= PRIV_M;
    end

    assign lvl_o     = stk_q;
    assign mem_prv_o = mem_prv_q;

endmodule

// File: rtl/trap_record.sv
// Trap result registers: strobe, redirect address, cause, exception PC and the
// load reservation flag.
// Assumes trap_go is already held off for the cycle after a strobe.
module trap_record #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_go,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] vec_in,
    input  logic            resv_set,
    output logic            trap_take,
    output logic [XLEN-1:0] trap_pc,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] epc,
    output logic            resv_valid
);

    // One-cycle strobe following each accepted trap
    always_ff @(posedge clk) begin
        if (!rst_n) trap_take <= 1'b0;
        else        trap_take <= trap_go;
    end

    // Capture redirect, cause and exception PC on trap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pc <= '0;
            cause   <= '0;
            epc     <= '0;
        end else if (trap_go) begin
            trap_pc <= vec_in;
            cause   <= cause_in;
            epc     <= pc_in;
        end
    end

    // Reservation flag: a trap clears it and wins over a set in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        resv_valid <= 1'b0;
        else if (trap_go)  resv_valid <= 1'b0;
        else if (resv_set) resv_valid <= 1'b1;
    end

endmodule

// File: rtl/trap_priv_ctrl.sv
// Top of the privilege stack trap controller. It arbitrates trap sources,
// shifts the three-level privilege stack on trap and return, and records the
// trap results.
// Assumes all requests are synchronous to clk. Trap beats return.
module trap_priv_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msw_pend_i,
    input  logic              host_msg_i,
    input  logic              ssw_pend_i,
    input  logic              stmr_pend_i,
    input  logic              stmr_en_i,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              ret_req_i,
    input  logic              resv_set_i,
    output logic              trap_take_o,
    output logic [XLEN-1:0]   trap_pc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [1:0]        priv_o,
    output logic              ie_o,
    output logic [1:0]        priv1_o,
    output logic              ie1_o,
    output logic [1:0]        priv2_o,
    output logic              ie2_o,
    output logic [1:0]        mem_priv_o,
    output logic              resv_valid_o
);

    localparam int LEVELS = 3;
    localparam int VEC_PAD = XLEN - 2 - VEC_SHIFT;

    lvl_t            lvl [LEVELS];
    priv_e           mem_prv;
    logic            src_hit;
    logic            trap_go;
    logic            ret_go;
    logic [XLEN-1:0] cause_w;
    logic [XLEN-1:0] vec_w;

    irq_select #(.XLEN(XLEN), .CODE_W(CODE_W)) u_sel (
        .cur_prv   (lvl[0].prv),
        .cur_ie    (lvl[0].ie),
        .msw_pend  (msw_pend_i),
        .host_msg  (host_msg_i),
        .ssw_pend  (ssw_pend_i),
        .stmr_pend (stmr_pend_i),
        .stmr_en   (stmr_en_i),
        .exc_req   (exc_req_i),
        .exc_code  (exc_code_i),
        .hit       (src_hit),
        .cause     (cause_w)
    );

    // Accept a trap unless the strobe of the previous one is still high; return only without trap
    always_comb begin
        trap_go = src_hit && !trap_take_o;
        ret_go  = ret_req_i && !trap_go;
        vec_w   = {{VEC_PAD{1'b0}}, lvl[0].prv, {VEC_SHIFT{1'b0}}};
    end

    priv_stack #(.LEVELS(LEVELS)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (trap_go),
        .pop       (ret_go),
        .lvl_o     (lvl),
        .mem_prv_o (mem_prv)
    );

    trap_record #(.XLEN(XLEN)) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_go    (trap_go),
        .cause_in   (cause_w),
        .pc_in      (pc_i),
        .vec_in     (vec_w),
        .resv_set   (resv_set_i),
        .trap_take  (trap_take_o),
        .trap_pc    (trap_pc_o),
        .cause      (cause_o),
        .epc        (epc_o),
        .resv_valid (resv_valid_o)
    );

    assign priv_o     = lvl[0].prv;
    assign ie_o       = lvl[0].ie;
    assign priv1_o    = lvl[1].prv;
    assign ie1_o      = lvl[1].ie;
    assign priv2_o    = lvl[2].prv;
    assign ie2_o      = lvl[2].ie;
    assign mem_priv_o = mem_prv;

endmodule

// File: rtl/trap_priv_chk.sv
// Property checker for trap_priv_ctrl, attached by bind. It observes ports only.
module trap_priv_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            msw_pend_i,
    input logic            host_msg_i,
    input logic            exc_req_i,
    input logic            ret_req_i,
    input logic            trap_take_o,
    input logic [XLEN-1:0] trap_pc_o,
    input logic [XLEN-1:0] cause_o,
    input logic [1:0]      priv_o,
    input logic            ie_o,
    input logic [1:0]      priv1_o,
    input logic            ie1_o,
    input logic [1:0]      priv2_o,
    input logic            ie2_o,
    input logic [1:0]      mem_priv_o,
    input logic            resv_valid_o
);

    logic past_ok;

    // Marks that at least one clocked cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take_o |=> !trap_take_o); // R8

    AST_TRAP_MLEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take_o |-> (priv_o == 2'd3 && !ie_o && mem_priv_o == 2'd3)); // R2

    AST_TRAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trap_take_o) |-> (priv1_o == $past(priv_o) && ie1_o == $past(ie_o)
                                      && priv2_o == $past(priv1_o) && ie2_o == $past(ie1_o))); // R2

    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trap_take_o) |-> (trap_pc_o == {{(XLEN-8){1'b0}}, $past(priv_o), 6'b0})); // R4

    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !trap_take_o && $past(ret_req_i)) |->
            (priv_o == $past(priv1_o) && ie_o == $past(ie1_o) && priv1_o == $past(priv2_o)
             && priv2_o == 2'd0 && ie2_o)); // R3

    AST_M_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(priv_o == 2'd3 && !ie_o && !exc_req_i)) |-> !trap_take_o); // R5

    AST_S_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!exc_req_i && !msw_pend_i && !host_msg_i
                          && (priv_o == 2'd3 || (priv_o == 2'd1 && !ie_o)))) |-> !trap_take_o); // R6

    AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take_o && cause_o[XLEN-1]) |-> (cause_o[XLEN-2:0] <= 2)); // R7

    AST_RESV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take_o |-> !resv_valid_o); // R10

endmodule

bind trap_priv_ctrl trap_priv_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msw_pend_i   (msw_pend_i),
    .host_msg_i   (host_msg_i),
    .exc_req_i    (exc_req_i),
    .ret_req_i    (ret_req_i),
    .trap_take_o  (trap_take_o),
    .trap_pc_o    (trap_pc_o),
    .cause_o      (cause_o),
    .priv_o       (priv_o),
    .ie_o         (ie_o),
    .priv1_o      (priv1_o),
    .ie1_o        (ie1_o),
    .priv2_o      (priv2_o),
    .ie2_o        (ie2_o),
    .mem_priv_o   (mem_priv_o),
    .resv_valid_o (resv_valid_o)
);

// File: tb/sim_trap_priv_ctrl.sv
module sim_trap_priv_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int CODE_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msw, host, ssw, stmr, sten, exc, ret, rset;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   pc;
    logic              take;
    logic [XLEN-1:0]   tpc, cause, epc;
    logic [1:0]        p0, p1, p2, mp;
    logic              i0, i1, i2, resv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench model state
    logic [1:0]      e_p0, e_p1, e_p2, e_mp;
    logic            e_i0, e_i1, e_i2, e_take, e_resv;
    logic [XLEN-1:0] e_tpc, e_cause, e_epc;
    bit              ev_trap, ev_ret;

    trap_priv_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .msw_pend_i(msw), .host_msg_i(host), .ssw_pend_i(ssw),
        .stmr_pend_i(stmr), .stmr_en_i(sten), .exc_req_i(exc), .exc_code_i(code), .pc_i(pc),
        .ret_req_i(ret), .resv_set_i(rset), .trap_take_o(take), .trap_pc_o(tpc),
        .cause_o(cause), .epc_o(epc), .priv_o(p0), .ie_o(i0), .priv1_o(p1), .ie1_o(i1),
        .priv2_o(p2), .ie2_o(i2), .mem_priv_o(mp), .resv_valid_o(resv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] irq_cause(input logic [1:0] num);
        irq_cause = {1'b1, {(XLEN-3){1'b0}}, num};
    endfunction

    // Expected next state from the requirements and the inputs now applied
    task automatic model_step();
        bit m_ok, s_ok, hit, go;
        logic [XLEN-1:0] c;
        m_ok = (e_p0 != 2'd3) || e_i0;
        s_ok = (e_p0 == 2'd0) || (e_p0 == 2'd1 && e_i0);
        hit = 1'b1;
        if (exc)                        c = {{(XLEN-CODE_W){1'b0}}, code};
        else if (m_ok && msw)           c = irq_cause(2'd0);
        else if (m_ok && host)          c = irq_cause(2'd2);
        else if (s_ok && ssw)           c = irq_cause(2'd0);
        else if (s_ok && stmr && sten)  c = irq_cause(2'd1);
        else begin c = '0; hit = 1'b0; end
        go = hit && !e_take;
        ev_trap = go;
        ev_ret  = ret && !go;
        if (go) begin
            e_tpc = {{(XLEN-8){1'b0}}, e_p0, 6'b0};
            e_cause = c;
            e_epc = pc;
            e_p2 = e_p1; e_i2 = e_i1;
            e_p1 = e_p0; e_i1 = e_i0;
            e_p0 = 2'd3; e_i0 = 1'b0; e_mp = 2'd3;
            e_resv = 1'b0;
        end else begin
            if (ev_ret) begin
                e_p0 = e_p1; e_i0 = e_i1;
                e_p1 = e_p2; e_i1 = e_i2;
                e_p2 = 2'd0; e_i2 = 1'b1;
            end
            if (rset) e_resv = 1'b1;
        end
        e_take = go;
    endtask

    task automatic compare(input string note);
        string ts;
        ts = ev_trap ? "R2" : (ev_ret ? "R3" : "R5 R6");
        check(ev_trap ? "R8" : "R5 R6", {note, " strobe"}, 64'(take), 64'(e_take));
        check(ts, {note, " status"}, 64'({p0, i0, p1, i1, p2, i2, mp}),
              64'({e_p0, e_i0, e_p1, e_i1, e_p2, e_i2, e_mp}));
        check("R4", {note, " redirect"}, 64'(tpc), 64'(e_tpc));
        check("R7", {note, " cause"}, 64'(cause), 64'(e_cause));
        check("R9", {note, " epc"}, 64'(epc), 64'(e_epc));
        check("R10", {note, " reservation"}, 64'(resv), 64'(e_resv));
    endtask

    task automatic drive(input logic a_msw, a_host, a_ssw, a_stmr, a_sten, a_exc, a_ret,
                         a_rset, input logic [CODE_W-1:0] a_code, input logic [XLEN-1:0] a_pc,
                         input string note);
        @(negedge clk);
        msw = a_msw; host = a_host; ssw = a_ssw; stmr = a_stmr; sten = a_sten;
        exc = a_exc; ret = a_ret; rset = a_rset; code = a_code; pc = a_pc;
        model_step();
        @(posedge clk);
        #1;
        compare(note);
    endtask

    task automatic idle(input string note);
        drive(0, 0, 0, 0, 0, 0, 0, 0, '0, '0, note);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        msw = 0; host = 0; ssw = 0; stmr = 0; sten = 0; exc = 0; ret = 0; rset = 0;
        code = '0; pc = '0;
        e_p0 = 2'd3; e_i0 = 0; e_p1 = 2'd1; e_i1 = 0; e_p2 = 2'd1; e_i2 = 0; e_mp = 2'd0;
        e_take = 0; e_resv = 0; e_tpc = '0; e_cause = '0; e_epc = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "reset status", 64'({p0, i0, p1, i1, p2, i2, mp}),
              64'({2'd3, 1'b0, 2'd1, 1'b0, 2'd1, 1'b0, 2'd0}));
        check("R1", "reset results", 64'({take, resv}), 64'(0));
        check("R1", "reset cause/epc/pc", 64'(cause | epc | tpc), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R8: exception held for two cycles, second one blocked by the strobe
        drive(0, 0, 0, 0, 0, 1, 0, 1, 5'd7, 32'h100, "exc held a");
        drive(0, 0, 0, 0, 0, 1, 0, 0, 5'd7, 32'h104, "exc held b");
        idle("after exc");
        // R3: unwind three returns down to user level
        drive(0, 0, 0, 0, 0, 0, 1, 0, '0, '0, "ret 1");
        drive(0, 0, 0, 0, 0, 0, 1, 0, '0, '0, "ret 2");
        drive(0, 0, 0, 0, 0, 0, 1, 0, '0, '0, "ret 3");
        // R5 R7: at user level, machine software beats host message; vector from U
        drive(1, 1, 1, 1, 1, 0, 0, 1, '0, 32'h200, "irq at U");
        idle("gap");
        // R5 R6: in M with enable clear, all interrupts masked
        drive(1, 1, 1, 1, 1, 0, 0, 0, '0, 32'h300, "masked in M");
        // R3: return in a trapping cycle is ignored
        drive(0, 0, 0, 0, 0, 1, 1, 0, 5'd3, 32'h400, "exc with ret");
        idle("gap 2");
        // R10: reservation set and trap in the same cycle
        drive(0, 0, 0, 0, 0, 0, 0, 1, '0, '0, "resv set");
        drive(0, 0, 0, 0, 0, 1, 0, 1, 5'd2, 32'h500, "resv vs trap");
        idle("gap 3");

        // Mixed random stimulus
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            drive(($urandom % 10) == 0, ($urandom % 12) == 0, ($urandom % 8) == 0,
                  ($urandom % 6) == 0, r[0], ($urandom % 14) == 0, ($urandom % 3) == 0,
                  ($urandom % 4) == 0, CODE_W'($urandom), $urandom, "random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule